// File: doc/BRIEF.md
# Single-Error-Correcting Word Memory

A sixteen-entry synchronous memory that holds 11-bit data words in protected form. Each stored entry is sixteen bits: a 15-position Hamming codeword (eleven data bits plus four check bits) and one overall-parity bit. The overall-parity bit lets the block tell a single flipped bit from two flipped bits.

A write encodes the incoming data and stores the protected word. A read fetches the word, regenerates the check bits, and forms a syndrome. It then returns the data in one of three states: clean, corrected, or flagged as uncorrectable. The result, a valid strobe and two status flags appear one cycle after the read request.

A write-side XOR mask exists for fault injection. It lets a test flip any chosen set of stored bits as they are written.

Top module: `ecc_word_mem`

## Requirements
- R1: Codeword positions are numbered 1 to 15. Positions 1, 2, 4 and 8 hold check bits. Data bit 0 sits at position 3, and the remaining data bits fill positions 5, 6, 7, 9, 10, 11, 12, 13, 14 and 15 in ascending order.
- R2: The four check bits equal the XOR of the 4-bit position numbers of every data position holding a 1. The sixteenth stored bit makes the parity of all sixteen stored bits even, so a word written with a zero mask produces a zero syndrome.
- R3: When `rd_en` is high at a rising edge, `rd_valid` is high for the following cycle, together with `rd_data`, `rd_single_err` and `rd_double_err` for that read. `rd_valid` is low in every cycle that does not follow a read request.
- R4: A read of an entry written with a zero mask returns the written data, with both status flags low.
- R5: If exactly one of codeword positions 1 to 15 is flipped, the read returns the original data and raises `rd_single_err`.
- R6: If only the overall-parity bit is flipped, the read returns the original data and raises `rd_single_err`.
- R7: If any two distinct stored bits are flipped, the read raises `rd_double_err` and keeps `rd_single_err` low. `rd_data` then carries the fetched data bits without correction.
- R8: `rd_single_err` and `rd_double_err` are never high together, and both are low whenever `rd_valid` is low.
- R9: Bit k of `wr_flip_mask` inverts stored bit k as the word is written. Bit k for k = 0 to 14 is codeword position k+1, and bit 15 is the overall-parity bit.
- R10: A read and a write to the same address in the same cycle return the contents held before that write. The write takes effect for later reads.
- R11: After reset, `rd_valid`, `rd_data` and both flags are zero. Each of the sixteen entries, selected by a 4-bit address, holds its own value independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Write entry index |
| wr_data | input | 11 | Data word to store |
| wr_flip_mask | input | 16 | Debug XOR mask applied to the stored word |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read entry index |
| rd_valid | output | 1 | One-cycle strobe marking a read result |
| rd_data | output | 11 | Data returned by the read, after correction |
| rd_single_err | output | 1 | Read hit one flipped bit, which was fixed |
| rd_double_err | output | 1 | Read hit two flipped bits, which cannot be fixed |

## Verification
The hardest states to reach from the ports are corrupted stored words, because a normal write always stores a consistent codeword. The bench reaches them through the flip mask. It sweeps all sixteen single-bit masks and all 120 two-bit masks over several data values. Each double-flip expectation comes from an independent position map, so a wrong data-to-position layout shows up as a mismatch in the uncorrected data.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

  localparam int DATA_W  = 11;
  localparam int CHK_W   = 4;
  localparam int CODE_W  = (1 << CHK_W) - 1;
  localparam int STORE_W = CODE_W + 1;
  localparam int DEPTH   = 16;
  localparam int ADDR_W  = $clog2(DEPTH);

  // True for positions that carry a check bit (1, 2, 4, 8).
  function automatic bit is_check_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // XOR of the position numbers of all set bits in a codeword.
  function automatic logic [CHK_W-1:0] set_pos_xor(logic [CODE_W-1:0] cw);
    logic [CHK_W-1:0] acc;
    acc = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (cw[p-1]) acc = acc ^ CHK_W'(p);
    end
    return acc;
  endfunction

  // Place data bits on the non-check positions, in ascending order.
  function automatic logic [CODE_W-1:0] spread_data(logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_check_pos(p)) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    return cw;
  endfunction

  // Pull data bits back out of the non-check positions.
  function automatic logic [DATA_W-1:0] collect_data(logic [CODE_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_check_pos(p)) begin
        d[k] = cw[p-1];
        k++;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_mem_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  data_in,
  input  logic [STORE_W-1:0] flip_mask,
  output logic [STORE_W-1:0] word_out
);

  logic [CODE_W-1:0] data_spread;
  logic [CHK_W-1:0]  chk;
  logic [CODE_W-1:0] cw;
  logic              ovr_par;

  always_comb begin
    data_spread = spread_data(data_in);
    chk         = set_pos_xor(data_spread);
  end

  // Drop each check bit onto its power-of-two position.
  always_comb begin
    cw = data_spread;
    for (int j = 0; j < CHK_W; j++) begin
      cw[(1 << j) - 1] = chk[j];
    end
  end

  always_comb begin
    ovr_par  = ^cw;
    word_out = {ovr_par, cw} ^ flip_mask;
  end

  // R2: an unmasked encoded word has zero syndrome and even overall parity
  clean_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_mask == '0) |-> ((set_pos_xor(word_out[CODE_W-1:0]) == '0) && !(^word_out)));

endmodule

// File: rtl/ecc_store.sv
module ecc_store
  import ecc_mem_pkg::*;
(
  input  logic               clk,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [STORE_W-1:0] wr_word,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [STORE_W-1:0] rd_word
);

  logic [STORE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_word;
  end

  assign rd_word = cells[rd_addr];

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_mem_pkg::*;
(
  input  logic [STORE_W-1:0] word_in,
  output logic [DATA_W-1:0]  data_out,
  output logic               single_err,
  output logic               double_err
);

  logic [CHK_W-1:0]  syndrome;
  logic              par_bad;
  logic [CODE_W-1:0] repaired;

  always_comb begin
    syndrome = set_pos_xor(word_in[CODE_W-1:0]);
    par_bad  = ^word_in;
  end

  // Invert the pointed-to position only when parity confirms an odd flip count.
  always_comb begin
    repaired = word_in[CODE_W-1:0];
    for (int p = 1; p <= CODE_W; p++) begin
      if (par_bad && (syndrome == CHK_W'(p))) repaired[p-1] = ~word_in[p-1];
    end
  end

  always_comb begin
    data_out   = collect_data(repaired);
    single_err = par_bad;
    double_err = (syndrome != '0) && !par_bad;
  end

endmodule

// File: rtl/ecc_word_mem.sv
module ecc_word_mem
  import ecc_mem_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [STORE_W-1:0] wr_flip_mask,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_single_err,
  output logic               rd_double_err
);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [STORE_W-1:0] enc_word;
  logic [STORE_W-1:0] fetched_word;
  logic [DATA_W-1:0]  dec_data;
  logic               dec_single;
  logic               dec_double;

  ecc_encoder u_enc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .data_in   (wr_data),
    .flip_mask (wr_flip_mask),
    .word_out  (enc_word)
  );

  ecc_store u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_word (enc_word),
    .rd_addr (rd_addr),
    .rd_word (fetched_word)
  );

  ecc_decoder u_dec (
    .word_in    (fetched_word),
    .data_out   (dec_data),
    .single_err (dec_single),
    .double_err (dec_double)
  );

  // Read result stage: next-state logic
  logic              valid_nxt, valid_q;
  logic [DATA_W-1:0] data_nxt, data_q;
  logic              sgl_nxt, sgl_q;
  logic              dbl_nxt, dbl_q;

  always_comb begin
    valid_nxt = rd_en;
    data_nxt  = rd_en ? dec_data : data_q;
    sgl_nxt   = rd_en & dec_single;
    dbl_nxt   = rd_en & dec_double;
  end

  // Read result stage: registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      sgl_q   <= 1'b0;
      dbl_q   <= 1'b0;
    end else begin
      valid_q <= valid_nxt;
      data_q  <= data_nxt;
      sgl_q   <= sgl_nxt;
      dbl_q   <= dbl_nxt;
    end
  end

  assign rd_valid      = valid_q;
  assign rd_data       = data_q;
  assign rd_single_err = sgl_q;
  assign rd_double_err = dbl_q;

  // R3
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_en |=> rd_valid);

  // R3
  valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_en |=> !rd_valid);

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(rd_single_err && rd_double_err));

  // R8
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_valid |-> (!rd_single_err && !rd_double_err));

endmodule

// File: tb/tb_ecc_word_mem.sv
`timescale 1ns/1ps
module tb_ecc_word_mem;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [10:0] wr_data;
  logic [15:0] wr_flip_mask;
  logic        rd_en;
  logic [3:0]  rd_addr;
  logic        rd_valid;
  logic [10:0] rd_data;
  logic        rd_single_err;
  logic        rd_double_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ecc_word_mem dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_flip_mask  (wr_flip_mask),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .rd_single_err (rd_single_err),
    .rd_double_err (rd_double_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Data bit index -> codeword position, from R1 (skip 1, 2, 4, 8).
  function automatic int data_pos(int i);
    int k = 0;
    for (int p = 1; p <= 15; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == i) return p;
        k++;
      end
    end
    return 0;
  endfunction

  // Data bits that a stored-bit mask inverts, per R9 and R1.
  function automatic logic [10:0] data_flips(logic [15:0] m);
    logic [10:0] r = '0;
    for (int i = 0; i < 11; i++) r[i] = m[data_pos(i) - 1];
    return r;
  endfunction

  function automatic logic [10:0] pattern(int s);
    return 11'((s * 1237 + 91) ^ (s << 5));
  endfunction

  task automatic do_write(input logic [3:0] a, input logic [10:0] d, input logic [15:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_flip_mask = m;
    @(negedge clk);
    wr_en = 1'b0; wr_flip_mask = '0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [10:0] ed,
                         input bit es, input bit edb, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b1, "R3 valid", int'(rd_valid), 1);
    chk(rd_data == ed, req, int'(rd_data), int'(ed));
    chk(rd_single_err == es, {req, " single"}, int'(rd_single_err), int'(es));
    chk(rd_double_err == edb, {req, " double"}, int'(rd_double_err), int'(edb));
    @(negedge clk);
    chk(rd_valid == 1'b0, "R3 one-cycle valid", int'(rd_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    wr_flip_mask = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk(rd_valid == 1'b0, "R11 valid", int'(rd_valid), 0);
    chk(rd_data == '0, "R11 data", int'(rd_data), 0);
    chk(!rd_single_err && !rd_double_err, "R11 flags",
        int'({rd_single_err, rd_double_err}), 0);

    // R4/R11: fill all entries, then read all back (independence)
    for (int a = 0; a < 16; a++) do_write(4'(a), pattern(a), '0);
    for (int a = 0; a < 16; a++) do_read(4'(a), pattern(a), 1'b0, 1'b0, "R4 R11 clean");

    // R4: extreme data values
    do_write(4'd3, 11'h000, '0); do_read(4'd3, 11'h000, 1'b0, 1'b0, "R4 zeros");
    do_write(4'd3, 11'h7ff, '0); do_read(4'd3, 11'h7ff, 1'b0, 1'b0, "R4 ones");

    // R5/R6/R9: every single-bit flip on several data values
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 16; k++) begin
        logic [10:0] d;
        d = pattern(s * 7 + k);
        do_write(4'(k), d, 16'(1) << k);
        if (k == 15) do_read(4'(k), d, 1'b1, 1'b0, "R6 parity-bit flip");
        else         do_read(4'(k), d, 1'b1, 1'b0, "R5 R9 single flip");
      end
    end

    // R7/R1/R9: every two-bit flip, on two data values
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = a + 1; b < 16; b++) begin
          logic [15:0] m;
          logic [10:0] d;
          m = (16'(1) << a) | (16'(1) << b);
          d = pattern(100 + s * 13 + a + b);
          do_write(4'(a), d, m);
          do_read(4'(a), d ^ data_flips(m), 1'b0, 1'b1, "R7 R1 double flip");
        end
      end
    end

    // R10: same-cycle read and write to one address
    do_write(4'd9, 11'h2a5, '0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd9; wr_data = 11'h15a; wr_flip_mask = '0;
    rd_en = 1'b1; rd_addr = 4'd9;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_valid == 1'b1, "R10 valid", int'(rd_valid), 1);
    chk(rd_data == 11'h2a5, "R10 old data", int'(rd_data), 'h2a5);
    do_read(4'd9, 11'h15a, 1'b0, 1'b0, "R10 new data");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule